// File: doc/BRIEF.md
# Interrupt Controller CPU Interface

This block is the processor-facing side of an interrupt controller. An upstream distributor presents, as a level, the most urgent pending interrupt as a 24-bit ID with an 8-bit priority. The processor talks to the block through a single-cycle 32-bit register bus and receives one interrupt request line. A smaller priority number means a more urgent interrupt.

Software turns signalling on, sets a priority mask and a binary point. The binary point decides how many low priority bits are subpriority, so preemption is judged on group priority only. Reading the acknowledge register claims the pending interrupt. Its priority is pushed onto an active-priority stack, and the running priority follows the top of that stack. Writing the ID back to the end-of-interrupt register retires it. Bad register accesses are recorded in sticky status flags that are cleared by writing 1.

The distributor and bus pins are plain control pins with no valid/ready pairing. The block never stalls the bus: every access completes in the cycle it is presented. The pending input is sampled as a level with no back-pressure. The acknowledge strobe is a one-cycle pulse that the distributor must accept unconditionally.

Top module: `icpu_top`

## Requirements
- R1: After reset the control (0x000), mask (0x004), binary point (0x008) and status (0x02C) registers read 0. The running priority (0x014) reads 0xFF, the highest-pending register (0x018) reads 1023 while no interrupt is pending, and `irq_o` is low.
- R2: While control bit 0 is 0, `irq_o` stays low whatever is pending.
- R3: An interrupt is signalled only when its priority is strictly less than the mask value; an equal priority is not signalled.
- R4: With binary point N, the group priority is the priority with bits [N:0] cleared. A pending interrupt is signalled only if its group priority is strictly less than the group priority of the running priority.
- R5: A read of 0x00C while an interrupt is signalable returns its ID in bits [23:0]. The same read pulses `ack_valid_o` with that ID, pushes its priority onto the active stack and makes 0x014 report it.
- R6: A read of 0x00C when nothing is signalable returns 1023, does not pulse `ack_valid_o` and leaves the running priority unchanged.
- R7: A write to 0x010 whose bits [23:0] equal the top active ID pops it and restores the running priority to the next entry, or to 0xFF if the stack is empty. A write with any other ID changes nothing.
- R8: Fields are narrow. The mask is bits [7:0] and the binary point bits [2:0], and other bits read 0. Interrupt IDs use bits [23:0], and bits [31:24] of an end-of-interrupt write are ignored.
- R9: Status bits are sticky. Bit 0 is set by a read of an unmapped address, bit 1 by a write to one, bit 2 by a read of 0x010, and bit 3 by a write to 0x00C, 0x014, 0x018 or 0x0FC. Bit 4 is never set here. Writing 1 to a status bit clears it.
- R10: Unmapped reads return 0. Unmapped writes, and writes to read-only registers, change no register other than status; identification (0x0FC) keeps its fixed value.
- R11: Read data and `ack_valid_o` appear on the clock edge that samples the access. `irq_o` is registered and follows its conditions one edge later.
- R12: While the active stack (depth `DEPTH`, 4 by default) is full, nothing is signalled and acknowledge returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_valid_i | input | 1 | Distributor has a pending interrupt |
| pend_id_i | input | 24 | ID of the pending interrupt |
| pend_prio_i | input | 8 | Priority of the pending interrupt |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| ack_valid_o | output | 1 | One-cycle pulse: interrupt claimed |
| ack_id_o | output | 24 | ID claimed with the pulse |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Register writes take effect on the edge that samples them. Read data and the acknowledge pulse are valid on the edge after the access is presented, so the bench reads them at the following falling edge. `irq_o` trails any change of its inputs or of the registers by one more edge, so every request check waits one extra falling edge after the stimulus. A check at one time unit after an input change confirms that there is no combinational path to `irq_o`.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int OFF_CTRL  = 'h000;
  localparam int OFF_PMASK = 'h004;
  localparam int OFF_BPT   = 'h008;
  localparam int OFF_ACK   = 'h00C;
  localparam int OFF_EOI   = 'h010;
  localparam int OFF_RUN   = 'h014;
  localparam int OFF_HPEND = 'h018;
  localparam int OFF_STAT  = 'h02C;
  localparam int OFF_IDENT = 'h0FC;
  localparam int ST_W      = 5;
  localparam int SPURIOUS  = 1023;

  typedef enum logic [1:0] {
    ST_RD_HOLE = 2'd0,
    ST_WR_HOLE = 2'd1,
    ST_RD_WO   = 2'd2,
    ST_WR_RO   = 2'd3
  } st_bit_e;
endpackage

// File: rtl/icpu_prio_stack.sv
module icpu_prio_stack #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 24,
  parameter int PRIO_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [ID_W-1:0]   top_id,
  output logic [PRIO_W-1:0] top_prio,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  logic [ID_W-1:0]   id_mem   [DEPTH];
  logic [PRIO_W-1:0] prio_mem [DEPTH];

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (push && !full) count <= count + 1'b1;
    else if (pop && !empty) count <= count - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_mem[i]   <= '0;
        prio_mem[i] <= '1;
      end else if (push && !full && count == CNT_W'(i)) begin
        id_mem[i]   <= push_id;
        prio_mem[i] <= push_prio;
      end
    end
  end

  always_comb begin
    top_id   = '0;
    top_prio = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (count == CNT_W'(i + 1)) begin
        top_id   = id_mem[i];
        top_prio = prio_mem[i];
      end
    end
  end
endmodule

// File: rtl/icpu_gate.sv
module icpu_gate #(
  parameter int PRIO_W = 8,
  localparam int BP_W  = $clog2(PRIO_W)
) (
  input  logic              en,
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [BP_W-1:0]   bpt,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              stack_full,
  output logic              ok
);
  logic [PRIO_W:0]   low_bits;
  logic [PRIO_W-1:0] grp_mask;
  logic [PRIO_W-1:0] pend_grp;
  logic [PRIO_W-1:0] run_grp;

  always_comb begin
    low_bits = ((PRIO_W + 1)'(2) << bpt) - 1'b1;
    grp_mask = ~low_bits[PRIO_W-1:0];
    pend_grp = pend_prio & grp_mask;
    run_grp  = run_prio & grp_mask;
    ok = en && pend_valid && !stack_full
         && (pend_prio < pmask) && (pend_grp < run_grp);
  end
endmodule

// File: rtl/icpu_top.sv
module icpu_top
  import icpu_pkg::*;
#(
  parameter int          DEPTH  = 4,
  parameter int          ID_W   = 24,
  parameter int          PRIO_W = 8,
  parameter int          ADDR_W = 12,
  parameter logic [31:0] IDENT  = 32'h0010_0001,
  localparam int BP_W  = $clog2(PRIO_W),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_valid_i,
  input  logic [ID_W-1:0]   pend_id_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              ack_valid_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              irq_o
);
  localparam logic [ID_W-1:0] SPUR_ID = ID_W'(SPURIOUS);

  logic              ctrl_en;
  logic [PRIO_W-1:0] pmask_q;
  logic [BP_W-1:0]   bpt_q;
  logic [ST_W-1:0]   status_q;
  logic [ST_W-1:0]   status_d;
  logic [ID_W-1:0]   top_id;
  logic [PRIO_W-1:0] top_prio;
  logic              stk_empty, stk_full;
  logic [CNT_W-1:0]  stk_cnt;
  logic [PRIO_W-1:0] run_prio;
  logic              sig_ok;
  logic              rd, wr;
  logic is_ctrl, is_pmask, is_bpt, is_ack, is_eoi, is_run, is_hpend, is_stat, is_ident;
  logic known, ro_hit;
  logic ack_take, eoi_hit;
  logic [31:0] rd_val;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata_i[31:ID_W];

  assign rd = bus_sel_i && !bus_wr_i;
  assign wr = bus_sel_i && bus_wr_i;

  always_comb begin
    is_ctrl  = bus_addr_i == ADDR_W'(OFF_CTRL);
    is_pmask = bus_addr_i == ADDR_W'(OFF_PMASK);
    is_bpt   = bus_addr_i == ADDR_W'(OFF_BPT);
    is_ack   = bus_addr_i == ADDR_W'(OFF_ACK);
    is_eoi   = bus_addr_i == ADDR_W'(OFF_EOI);
    is_run   = bus_addr_i == ADDR_W'(OFF_RUN);
    is_hpend = bus_addr_i == ADDR_W'(OFF_HPEND);
    is_stat  = bus_addr_i == ADDR_W'(OFF_STAT);
    is_ident = bus_addr_i == ADDR_W'(OFF_IDENT);
    ro_hit   = is_ack || is_run || is_hpend || is_ident;
    known    = is_ctrl || is_pmask || is_bpt || is_eoi || is_stat || ro_hit;
  end

  assign run_prio = stk_empty ? '1 : top_prio;

  icpu_gate #(.PRIO_W(PRIO_W)) u_gate (
    .en(ctrl_en), .pend_valid(pend_valid_i), .pend_prio(pend_prio_i),
    .pmask(pmask_q), .bpt(bpt_q), .run_prio(run_prio),
    .stack_full(stk_full), .ok(sig_ok)
  );

  assign ack_take = rd && is_ack && sig_ok;
  assign eoi_hit  = wr && is_eoi && !stk_empty && (bus_wdata_i[ID_W-1:0] == top_id);

  icpu_prio_stack #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(ack_take), .push_id(pend_id_i), .push_prio(pend_prio_i),
    .pop(eoi_hit), .top_id(top_id), .top_prio(top_prio),
    .empty(stk_empty), .full(stk_full), .count(stk_cnt)
  );

  always_comb begin
    rd_val = '0;
    if (is_ctrl)  rd_val = 32'(ctrl_en);
    if (is_pmask) rd_val = 32'(pmask_q);
    if (is_bpt)   rd_val = 32'(bpt_q);
    if (is_ack)   rd_val = 32'(sig_ok ? pend_id_i : SPUR_ID);
    if (is_run)   rd_val = 32'(run_prio);
    if (is_hpend) rd_val = 32'(pend_valid_i ? pend_id_i : SPUR_ID);
    if (is_stat)  rd_val = 32'(status_q);
    if (is_ident) rd_val = IDENT;
  end

  always_comb begin
    status_d = status_q;
    if (wr && is_stat) status_d = status_q & ~bus_wdata_i[ST_W-1:0];
    if (rd && !known)  status_d[ST_RD_HOLE] = 1'b1;
    if (wr && !known)  status_d[ST_WR_HOLE] = 1'b1;
    if (rd && is_eoi)  status_d[ST_RD_WO]   = 1'b1;
    if (wr && ro_hit)  status_d[ST_WR_RO]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en     <= 1'b0;
      pmask_q     <= '0;
      bpt_q       <= '0;
      status_q    <= '0;
      bus_rdata_o <= '0;
      ack_valid_o <= 1'b0;
      ack_id_o    <= '0;
      irq_o       <= 1'b0;
    end else begin
      status_q    <= status_d;
      bus_rdata_o <= rd ? rd_val : '0;
      ack_valid_o <= ack_take;
      ack_id_o    <= ack_take ? pend_id_i : '0;
      irq_o       <= sig_ok;
      if (wr && is_ctrl)  ctrl_en <= bus_wdata_i[0];
      if (wr && is_pmask) pmask_q <= bus_wdata_i[PRIO_W-1:0];
      if (wr && is_bpt)   bpt_q   <= bus_wdata_i[BP_W-1:0];
    end
  end
endmodule

// File: rtl/icpu_top_chk.sv
module icpu_top_chk #(
  parameter int DEPTH  = 4,
  parameter int PRIO_W = 8,
  parameter int ADDR_W = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [PRIO_W-1:0] pend_prio,
  input logic [PRIO_W-1:0] pmask,
  input logic              irq,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ack_valid,
  input logic              eoi_hit,
  input logic [CNT_W-1:0]  cnt,
  input logic [4:0]        status
);
  // R2
  irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq);
  // R3
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_prio >= pmask) |=> !irq);
  // R7
  eoi_pops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> (cnt == $past(cnt) - 1'b1));
  // R12
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  // R9
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == ADDR_W'('h02C))
    |=> ((status & $past(status)) == $past(status)));
  // R11
  ack_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(bus_sel && !bus_wr));
endmodule

bind icpu_top icpu_top_chk #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .pend_prio(pend_prio_i), .pmask(pmask_q),
  .irq(irq_o), .bus_sel(bus_sel_i), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
  .ack_valid(ack_valid_o), .eoi_hit(eoi_hit), .cnt(stk_cnt), .status(status_q)
);

// File: tb/icpu_top_tb_top.sv
module icpu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pend_valid_i = 1'b0;
  logic [23:0] pend_id_i = '0;
  logic [7:0]  pend_prio_i = 8'hFF;
  logic        bus_sel_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        ack_valid_o;
  logic [23:0] ack_id_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic        last_ack_v;
  logic [23:0] last_ack_id;

  always #4 clk = ~clk;

  icpu_top dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 0; bus_wr_i = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
    @(negedge clk);
    d = bus_rdata_o; last_ack_v = ack_valid_o; last_ack_id = ack_id_o;
    bus_sel_i = 0;
  endtask

  task automatic rd_chk(string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic irq_chk(string req, logic exp);
    @(negedge clk);
    chk(req, 32'(irq_o), 32'(exp));
  endtask

  task automatic pend(logic v, logic [23:0] id, logic [7:0] p);
    pend_valid_i = v; pend_id_i = id; pend_prio_i = p;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 12'h000, 0);
    rd_chk("R1 mask", 12'h004, 0);
    rd_chk("R1 bpt", 12'h008, 0);
    rd_chk("R1 run", 12'h014, 32'hFF);
    rd_chk("R1 hpend", 12'h018, 1023);
    rd_chk("R1 stat", 12'h02C, 0);
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_enable;
    wr(12'h004, 32'hFF);
    pend(1, 24'd5, 8'h40);
    irq_chk("R2 disabled", 0);
    wr(12'h000, 1);
    irq_chk("R2 enabled", 1);
    wr(12'h000, 0);
    irq_chk("R2 disabled again", 0);
    wr(12'h000, 1);
  endtask

  task automatic t_mask;
    wr(12'h004, 32'h40);
    irq_chk("R3 equal masked", 0);
    wr(12'h004, 32'h41);
    irq_chk("R3 below mask", 1);
    wr(12'h004, 32'hFFFF_FF80);
    rd_chk("R8 mask width", 12'h004, 32'h80);
    wr(12'h004, 32'hFF);
  endtask

  task automatic t_ack_eoi;
    logic [31:0] d;
    pend(1, 24'h00ABCD, 8'h40);
    rd(12'h00C, d);
    chk("R5 ack id", d, 32'h00ABCD);
    chk("R5 ack strobe", {31'b0, last_ack_v}, 1);
    chk("R5 ack strobe id", 32'(last_ack_id), 32'h00ABCD);
    rd_chk("R5 running", 12'h014, 32'h40);
    irq_chk("R4 same group no preempt", 0);
    rd(12'h00C, d);
    chk("R6 spurious", d, 1023);
    chk("R6 no strobe", {31'b0, last_ack_v}, 0);
    rd_chk("R6 running kept", 12'h014, 32'h40);
    wr(12'h010, 32'h00ABCE);
    rd_chk("R7 wrong id ignored", 12'h014, 32'h40);
    wr(12'h010, 32'h5500ABCD);
    rd_chk("R8 R7 eoi upper bits ignored", 12'h014, 32'hFF);
  endtask

  task automatic t_bpt;
    logic [31:0] d;
    pend(1, 24'd20, 8'h50);
    rd(12'h00C, d);
    chk("R5 ack 0x50", d, 20);
    pend(1, 24'd21, 8'h44);
    irq_chk("R4 bpt0 preempt", 1);
    wr(12'h008, 5);
    irq_chk("R4 bpt5 same group", 0);
    wr(12'h008, 3);
    irq_chk("R4 bpt3 preempt", 1);
    wr(12'h008, 32'hFF);
    rd_chk("R8 bpt width", 12'h008, 7);
    wr(12'h008, 0);
    wr(12'h010, 20);
    rd_chk("R7 back to idle", 12'h014, 32'hFF);
  endtask

  task automatic t_stack;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      pend(1, 24'(10 + i), 8'(8'h80 - 8'h20 * i));
      rd(12'h00C, d);
      chk("R5 nested ack", d, 32'(10 + i));
    end
    rd_chk("R5 running deepest", 12'h014, 32'h20);
    pend(1, 24'd14, 8'h10);
    irq_chk("R12 full blocks irq", 0);
    rd(12'h00C, d);
    chk("R12 full ack spurious", d, 1023);
    wr(12'h010, 13);
    rd_chk("R7 restore 0x40", 12'h014, 32'h40);
    irq_chk("R12 room again", 1);
    wr(12'h010, 12);
    wr(12'h010, 11);
    rd_chk("R7 restore 0x80", 12'h014, 32'h80);
    wr(12'h010, 10);
    rd_chk("R7 empty idle", 12'h014, 32'hFF);
    pend(0, 0, 8'hFF);
  endtask

  task automatic t_status;
    rd_chk("R10 hole reads 0", 12'h030, 0);
    wr(12'h030, 32'hFFFF_FFFF);
    rd_chk("R9 rd WO reads 0", 12'h010, 0);
    wr(12'h014, 32'h0);
    rd_chk("R9 four flags", 12'h02C, 32'hF);
    wr(12'h02C, 32'h5);
    rd_chk("R9 w1c partial", 12'h02C, 32'hA);
    wr(12'h02C, 32'h1F);
    rd_chk("R9 w1c all", 12'h02C, 0);
  endtask

  task automatic t_unmapped;
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'h0);
    rd_chk("R10 ctrl kept", 12'h000, 1);
    rd_chk("R10 mask kept", 12'h004, 32'hFF);
    rd_chk("R10 bpt kept", 12'h008, 0);
    rd_chk("R10 ident kept", 12'h0FC, 32'h0010_0001);
    wr(12'h02C, 32'h1F);
  endtask

  task automatic t_timing;
    pend(1, 24'd30, 8'h30);
    #1;
    chk("R11 irq not combinational", 32'(irq_o), 0);
    irq_chk("R11 irq one edge later", 1);
    pend(0, 0, 8'hFF);
    irq_chk("R11 irq drops", 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_mask();
    t_ack_eoi();
    t_bpt();
    t_stack();
    t_status();
    t_unmapped();
    t_timing();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule